// File: doc/BRIEF.md
# Regional Kappa-Phi Track Histogram Accumulator

This block builds, for one azimuthal slice of a drift-chamber trigger, a two-dimensional count of track segments binned by curvature (kappa, 16 bins) and by local azimuth (phi, 10 bins). On every clock it accepts up to four segment hits, each tagged with a kappa bin and a local phi bin, and raises the count of the cell each valid hit names. Six such regions cover the full azimuth, giving a 16 by 60 picture once they are joined.

A single-cycle `bx_clear` pulse marks the start of a new bunch crossing. On that edge the counts gathered so far are copied into a frozen output bank, and counting restarts from zero. A small export sequencer then announces the frozen bank and, one clock later, presents the region's highest-phi column as a 16-entry vector. That vector goes on the ring bus to the neighbouring region, so that the regional histograms can be stitched across boundaries, and to the downstream decision stage.

The export sequencer has three states. `EXP_IDLE` waits; `bx_clear` moves it to `EXP_SNAP` (transition *freeze*). `EXP_SNAP` drives `frz_valid` for one cycle and goes to `EXP_EDGE` (transition *publish*) while loading the edge column, or stays in `EXP_SNAP` if another `bx_clear` arrives (transition *refreeze*). `EXP_EDGE` drives `edge_valid` for one cycle and returns to `EXP_IDLE` (transition *done*), or goes to `EXP_SNAP` on `bx_clear` (transition *freeze*).

Top module: `trh_region_hist`

## Requirements
- R1: After reset, `hist_out`, `edge_col`, `frz_valid`, `edge_valid` and `hit_err` are all zero, and every internal count is zero.
- R2: A hit h with `hit_valid[h]` high, kappa index `hit_kappa[5h+4:5h]` below 16 and phi index `hit_phi[4h+3:4h]` below 10 adds one to cell (kappa, phi); counts build up over cycles until the next clear. Cell (k, p) of `hist_out` is the 4-bit field starting at bit 4*(10k+p).
- R3: Several valid hits naming the same cell in the same clock are all counted in that clock.
- R4: Each count is 4 bits wide and stops at 15; further hits leave it at 15.
- R5: On the edge where `bx_clear` is high, `hist_out` takes the counts gathered before that cycle; hits presented in the clear cycle itself count towards the next crossing. `hist_out` changes on no other edge.
- R6: `frz_valid` is high for exactly the one cycle after each `bx_clear` edge.
- R7: One cycle after `frz_valid`, `edge_valid` is high for one cycle and `edge_col` holds column phi = 9 of `hist_out`, with kappa k in bits [4k+3:4k]; `edge_col` holds that value until the next publish.
- R8: A valid hit whose kappa index is 16 or more, or whose phi index is 10 or more, changes no count and sets `hit_err` from the next cycle on; `hit_err` stays high until reset.
- R9: Hits with `hit_valid` low change no count and do not set `hit_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bx_clear | input | 1 | One-cycle pulse starting a new bunch crossing |
| hit_valid | input | 4 | Per-hit valid flags |
| hit_kappa | input | 20 | Per-hit kappa index, 5 bits each, hit 0 lowest |
| hit_phi | input | 16 | Per-hit local phi index, 4 bits each, hit 0 lowest |
| hist_out | output | 640 | Frozen histogram, 160 cells of 4 bits, cell 10k+p |
| frz_valid | output | 1 | Frozen bank newly updated |
| edge_col | output | 64 | Edge phi column, 16 kappa entries of 4 bits |
| edge_valid | output | 1 | Edge column newly updated |
| hit_err | output | 1 | Sticky out-of-range hit flag |

## Verification
The bench aims at the cycle boundary around a clear: a hit presented together with `bx_clear` must land in the next crossing, so a design that freezes after adding it, or drops it, shows a wrong count in one of two successive snapshots. Four hits on one cell per clock over several clocks drive a count past 15; a design that wraps instead of stopping reports a small number, and one that sums only one hit per cell per clock reports too low a total in the table walk. Out-of-range indices such as kappa 16 or phi 10 are aimed at cells that would alias to real ones if the range check were missing, and the error flag is watched across a later clear to catch a flag that is not sticky. The edge column is compared against phi column 9 of the frozen bank one cycle after the freeze, which exposes a wrong column or an off-by-one publish cycle.

// File: rtl/trh_pkg.sv
package trh_pkg;

    // Export sequencer states
    typedef enum logic [1:0] {
        EXP_IDLE = 2'd0,
        EXP_SNAP = 2'd1,
        EXP_EDGE = 2'd2
    } exp_state_t;

endpackage

// File: rtl/trh_hit_decode.sv
module trh_hit_decode #(
    parameter int KBINS = 16,
    parameter int PBINS = 10,
    parameter int NHITS = 4,
    parameter int KIW   = $clog2(KBINS + 1),
    parameter int PIW   = $clog2(PBINS + 1)
) (
    input  logic [NHITS-1:0]       hit_valid,
    input  logic [NHITS*KIW-1:0]   hit_kappa,
    input  logic [NHITS*PIW-1:0]   hit_phi,
    output logic [NHITS-1:0]       hit_bad,
    output logic [NHITS*KBINS-1:0] kap_sel,
    output logic [NHITS*PBINS-1:0] phi_sel
);

    localparam logic [KIW-1:0] KLIM = KIW'(KBINS);
    localparam logic [PIW-1:0] PLIM = PIW'(PBINS);

    for (genvar h = 0; h < NHITS; h++) begin : g_hit
        logic [KIW-1:0] kidx;
        logic [PIW-1:0] pidx;
        logic           in_range;
        logic           usable;

        assign kidx     = hit_kappa[h*KIW +: KIW];
        assign pidx     = hit_phi[h*PIW +: PIW];
        assign in_range = (kidx < KLIM) && (pidx < PLIM);
        assign usable   = hit_valid[h] && in_range;
        assign hit_bad[h] = hit_valid[h] && !in_range;

        always_comb begin
            for (int k = 0; k < KBINS; k++) begin
                kap_sel[h*KBINS + k] = usable && (kidx == KIW'(k));
            end
            for (int p = 0; p < PBINS; p++) begin
                phi_sel[h*PBINS + p] = usable && (pidx == PIW'(p));
            end
        end
    end

endmodule

// File: rtl/trh_cell.sv
module trh_cell #(
    parameter int NHITS = 4,
    parameter int CW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [NHITS-1:0] match,
    output logic [CW-1:0]    frozen
);

    localparam int SW = $clog2(NHITS + 1);
    localparam int TW = CW + SW;
    localparam logic [TW-1:0] MAXV = TW'((1 << CW) - 1);

    logic [CW-1:0] live;
    logic [SW-1:0] hits_here;
    logic [TW-1:0] base;
    logic [TW-1:0] total;
    logic [CW-1:0] live_nxt;

    always_comb begin
        hits_here = SW'($countones(match));
        base      = clr ? '0 : TW'(live);
        total     = base + TW'(hits_here);
        live_nxt  = (total > MAXV) ? MAXV[CW-1:0] : total[CW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live   <= '0;
            frozen <= '0;
        end else begin
            live <= live_nxt;
            if (clr) begin
                frozen <= live;
            end
        end
    end

endmodule

// File: rtl/trh_export.sv
module trh_export
    import trh_pkg::*;
#(
    parameter int KBINS = 16,
    parameter int CW    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [KBINS*CW-1:0] edge_src,
    output logic                frz_valid,
    output logic                edge_valid,
    output logic [KBINS*CW-1:0] edge_col
);

    exp_state_t state;
    exp_state_t state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= EXP_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions: freeze, refreeze, publish, done
    always_comb begin
        state_nxt = state;
        unique case (state)
            EXP_IDLE: if (clr) state_nxt = EXP_SNAP;
            EXP_SNAP: state_nxt = clr ? EXP_SNAP : EXP_EDGE;
            EXP_EDGE: state_nxt = clr ? EXP_SNAP : EXP_IDLE;
            default:  state_nxt = EXP_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        frz_valid  = (state == EXP_SNAP);
        edge_valid = (state == EXP_EDGE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_col <= '0;
        end else if (state == EXP_SNAP && !clr) begin
            edge_col <= edge_src;
        end
    end

endmodule

// File: rtl/trh_region_hist.sv
module trh_region_hist #(
    parameter int KBINS = 16,
    parameter int PBINS = 10,
    parameter int NHITS = 4,
    parameter int CW    = 4,
    parameter int KIW   = $clog2(KBINS + 1),
    parameter int PIW   = $clog2(PBINS + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bx_clear,
    input  logic [NHITS-1:0]          hit_valid,
    input  logic [NHITS*KIW-1:0]      hit_kappa,
    input  logic [NHITS*PIW-1:0]      hit_phi,
    output logic [KBINS*PBINS*CW-1:0] hist_out,
    output logic                      frz_valid,
    output logic [KBINS*CW-1:0]       edge_col,
    output logic                      edge_valid,
    output logic                      hit_err
);

    localparam int EDGE_P = PBINS - 1;

    logic [NHITS-1:0]       hit_bad;
    logic [NHITS*KBINS-1:0] kap_sel;
    logic [NHITS*PBINS-1:0] phi_sel;
    logic [KBINS*CW-1:0]    edge_src;

    trh_hit_decode #(
        .KBINS(KBINS), .PBINS(PBINS), .NHITS(NHITS), .KIW(KIW), .PIW(PIW)
    ) u_dec (
        .hit_valid (hit_valid),
        .hit_kappa (hit_kappa),
        .hit_phi   (hit_phi),
        .hit_bad   (hit_bad),
        .kap_sel   (kap_sel),
        .phi_sel   (phi_sel)
    );

    for (genvar k = 0; k < KBINS; k++) begin : g_kap
        for (genvar p = 0; p < PBINS; p++) begin : g_phi
            logic [NHITS-1:0] match;
            for (genvar h = 0; h < NHITS; h++) begin : g_m
                assign match[h] = kap_sel[h*KBINS + k] & phi_sel[h*PBINS + p];
            end
            trh_cell #(.NHITS(NHITS), .CW(CW)) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .clr    (bx_clear),
                .match  (match),
                .frozen (hist_out[(k*PBINS + p)*CW +: CW])
            );
        end
        assign edge_src[k*CW +: CW] = hist_out[(k*PBINS + EDGE_P)*CW +: CW];
    end

    trh_export #(.KBINS(KBINS), .CW(CW)) u_exp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (bx_clear),
        .edge_src   (edge_src),
        .frz_valid  (frz_valid),
        .edge_valid (edge_valid),
        .edge_col   (edge_col)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_err <= 1'b0;
        end else if (|hit_bad) begin
            hit_err <= 1'b1;
        end
    end

endmodule

// File: rtl/trh_region_hist_chk.sv
module trh_region_hist_chk #(
    parameter int KBINS = 16,
    parameter int PBINS = 10,
    parameter int NHITS = 4,
    parameter int CW    = 4,
    parameter int KIW   = $clog2(KBINS + 1),
    parameter int PIW   = $clog2(PBINS + 1)
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bx_clear,
    input logic [NHITS-1:0]          hit_valid,
    input logic [NHITS*KIW-1:0]      hit_kappa,
    input logic [NHITS*PIW-1:0]      hit_phi,
    input logic [KBINS*PBINS*CW-1:0] hist_out,
    input logic                      frz_valid,
    input logic [KBINS*CW-1:0]       edge_col,
    input logic                      edge_valid,
    input logic                      hit_err
);

    logic [KBINS*CW-1:0] col_view;

    always_comb begin
        for (int k = 0; k < KBINS; k++) begin
            col_view[k*CW +: CW] = hist_out[(k*PBINS + PBINS - 1)*CW +: CW];
        end
    end

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit_err |=> hit_err);

    for (genvar h = 0; h < NHITS; h++) begin : g_bad
        // R8
        bad_hit_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_valid[h] && ((hit_kappa[h*KIW +: KIW] >= KIW'(KBINS)) ||
                              (hit_phi[h*PIW +: PIW] >= PIW'(PBINS))))
            |=> hit_err);
    end

    // R6
    frz_follows_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bx_clear |=> frz_valid);

    // R6
    frz_needs_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frz_valid |-> $past(bx_clear));

    // R5
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bx_clear |=> $stable(hist_out));

    // R7
    edge_after_frz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid |-> $past(frz_valid));

    // R7
    edge_content_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_valid |-> (edge_col == col_view));

    // R6
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frz_valid, edge_valid}));

endmodule

bind trh_region_hist trh_region_hist_chk #(
    .KBINS(KBINS), .PBINS(PBINS), .NHITS(NHITS), .CW(CW), .KIW(KIW), .PIW(PIW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bx_clear   (bx_clear),
    .hit_valid  (hit_valid),
    .hit_kappa  (hit_kappa),
    .hit_phi    (hit_phi),
    .hist_out   (hist_out),
    .frz_valid  (frz_valid),
    .edge_col   (edge_col),
    .edge_valid (edge_valid),
    .hit_err    (hit_err)
);

// File: tb/sim_trh_region_hist.sv
module sim_trh_region_hist;

    localparam int KB = 16;
    localparam int PB = 10;
    localparam int NH = 4;
    localparam int CW = 4;
    localparam int NC = KB * PB;

    logic          clk;
    logic          rst_n;
    logic          bx_clear;
    logic [3:0]    hit_valid;
    logic [19:0]   hit_kappa;
    logic [15:0]   hit_phi;
    logic [639:0]  hist_out;
    logic          frz_valid;
    logic [63:0]   edge_col;
    logic          edge_valid;
    logic          hit_err;

    int checks;
    int failures;
    int model [NC];
    int snap  [NC];

    // Hit word: hit h at bits [10h+9:10h] = {valid, kappa[4:0], phi[3:0]}
    localparam int NV = 12;
    localparam logic [39:0] VEC [NV] = '{
        {1'b0,5'd0,4'd0,  1'b0,5'd0,4'd0,  1'b0,5'd0,4'd0,  1'b1,5'd0,4'd0},
        {1'b1,5'd15,4'd9, 1'b1,5'd15,4'd9, 1'b1,5'd15,4'd9, 1'b1,5'd15,4'd9},
        {1'b1,5'd2,4'd3,  1'b1,5'd7,4'd9,  1'b1,5'd2,4'd3,  1'b1,5'd8,4'd1},
        {1'b0,5'd0,4'd0,  1'b1,5'd7,4'd9,  1'b0,5'd0,4'd0,  1'b1,5'd4,4'd4},
        {1'b1,5'd11,4'd6, 1'b1,5'd12,4'd6, 1'b1,5'd13,4'd6, 1'b1,5'd14,4'd6},
        {1'b1,5'd0,4'd9,  1'b1,5'd1,4'd9,  1'b1,5'd2,4'd9,  1'b1,5'd3,4'd9},
        {1'b1,5'd9,4'd5,  1'b1,5'd9,4'd5,  1'b0,5'd9,4'd5,  1'b1,5'd9,4'd5},
        {1'b0,5'd0,4'd0,  1'b0,5'd0,4'd0,  1'b0,5'd0,4'd0,  1'b0,5'd0,4'd0},
        {1'b1,5'd15,4'd0, 1'b1,5'd0,4'd9,  1'b1,5'd15,4'd9, 1'b1,5'd7,4'd9},
        {1'b1,5'd5,4'd2,  1'b0,5'd6,4'd2,  1'b1,5'd5,4'd2,  1'b0,5'd6,4'd2},
        {1'b1,5'd15,4'd9, 1'b1,5'd10,4'd8, 1'b1,5'd3,4'd7,  1'b1,5'd1,4'd1},
        {1'b1,5'd7,4'd9,  1'b1,5'd7,4'd9,  1'b1,5'd7,4'd9,  1'b1,5'd0,4'd0}
    };

    trh_region_hist u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .bx_clear   (bx_clear),
        .hit_valid  (hit_valid),
        .hit_kappa  (hit_kappa),
        .hit_phi    (hit_phi),
        .hist_out   (hist_out),
        .frz_valid  (frz_valid),
        .edge_col   (edge_col),
        .edge_valid (edge_valid),
        .hit_err    (hit_err)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] cell_of(input int idx);
        return hist_out[idx*CW +: CW];
    endfunction

    task automatic check_bank(input string req);
        int bad = -1;
        for (int i = 0; i < NC; i++) begin
            if (bad < 0 && int'(cell_of(i)) != snap[i]) bad = i;
        end
        if (bad < 0) check(1'b1, req, "bank", 0, 0);
        else check(1'b0, req, $sformatf("bank cell %0d", bad),
                   64'(cell_of(bad)), 64'(snap[bad]));
    endtask

    function automatic logic [63:0] exp_edge();
        logic [63:0] e;
        for (int k = 0; k < KB; k++) e[k*CW +: CW] = 4'(snap[k*PB + PB - 1]);
        return e;
    endfunction

    // Drive one cycle of hits (and optional clear); returns at the next negedge
    task automatic step(input logic [39:0] w, input logic clr);
        for (int h = 0; h < NH; h++) begin
            hit_valid[h]        = w[h*10 + 9];
            hit_kappa[h*5 +: 5] = w[h*10 + 4 +: 5];
            hit_phi[h*4 +: 4]   = w[h*10 +: 4];
        end
        bx_clear = clr;
        @(posedge clk);
        if (clr) begin
            snap = model;
            for (int i = 0; i < NC; i++) model[i] = 0;
        end
        for (int h = 0; h < NH; h++) begin
            int kk = int'(w[h*10 + 4 +: 5]);
            int pp = int'(w[h*10 +: 4]);
            if (w[h*10 + 9] && kk < KB && pp < PB && model[kk*PB + pp] < 15)
                model[kk*PB + pp]++;
        end
        @(negedge clk);
        hit_valid = '0;
        hit_kappa = '0;
        hit_phi   = '0;
        bx_clear  = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NC; i++) begin
            model[i] = 0;
            snap[i]  = 0;
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        checks = 0;
        failures = 0;
        bx_clear = 1'b0;
        hit_valid = '0;
        hit_kappa = '0;
        hit_phi = '0;
        do_reset();

        // R1 reset state
        check(hist_out == '0, "R1", "hist_out zero", 64'(|hist_out), 0);
        check(edge_col == '0, "R1", "edge_col zero", edge_col, 0);
        check({frz_valid, edge_valid, hit_err} == 3'b000, "R1", "flags low",
              64'({frz_valid, edge_valid, hit_err}), 0);

        // Table walk: R2 accumulation, R3 same-cell sums, R9 invalid hits
        for (int v = 0; v < NV; v++) step(VEC[v], 1'b0);
        check(hist_out == '0, "R5", "bank unchanged without clear",
              64'(|hist_out), 0);
        check(hit_err == 1'b0, "R9", "no error from table", 64'(hit_err), 0);
        step('0, 1'b1);
        check(frz_valid == 1'b1, "R6", "frz_valid after clear", 64'(frz_valid), 1);
        check_bank("R2 R3");
        check(int'(cell_of(15*PB + 9)) == 6, "R3", "cell(15,9)",
              64'(cell_of(15*PB + 9)), 6);
        @(negedge clk);
        check(edge_valid && !frz_valid, "R7", "edge_valid timing",
              64'({edge_valid, frz_valid}), 64'(2'b10));
        check(edge_col == exp_edge(), "R7", "edge column", edge_col, exp_edge());
        @(negedge clk);
        check(!edge_valid && !frz_valid, "R6", "pulses end",
              64'({edge_valid, frz_valid}), 0);

        // R4 saturation: 20 hits on cell (3,9)
        for (int i = 0; i < 5; i++)
            step({1'b1,5'd3,4'd9, 1'b1,5'd3,4'd9, 1'b1,5'd3,4'd9, 1'b1,5'd3,4'd9}, 1'b0);
        step('0, 1'b1);
        check(int'(cell_of(3*PB + 9)) == 15, "R4", "saturated cell",
              64'(cell_of(3*PB + 9)), 15);
        check_bank("R4");
        @(negedge clk);
        check(edge_col[3*CW +: CW] == 4'd15, "R7", "edge kappa 3",
              64'(edge_col[3*CW +: CW]), 15);

        // R5 hit in clear cycle belongs to the next crossing
        step({30'd0, 1'b1,5'd0,4'd0}, 1'b1);
        check(int'(cell_of(0)) == 0, "R5", "clear-cycle hit excluded",
              64'(cell_of(0)), 0);
        check_bank("R5");
        repeat (2) @(negedge clk);
        step('0, 1'b1);
        check(int'(cell_of(0)) == 1, "R5", "clear-cycle hit in next",
              64'(cell_of(0)), 1);

        // R9 invalid hits ignored
        step({1'b0,5'd1,4'd1, 1'b0,5'd1,4'd1, 1'b0,5'd20,4'd12, 1'b0,5'd1,4'd1}, 1'b0);
        check(hit_err == 1'b0, "R9", "no error from invalid", 64'(hit_err), 0);
        repeat (2) @(negedge clk);
        step('0, 1'b1);
        check_bank("R9");

        // R8 out-of-range hits dropped, sticky flag
        repeat (2) @(negedge clk);
        step({1'b1,5'd16,4'd0, 1'b1,5'd2,4'd10, 1'b1,5'd1,4'd1, 1'b1,5'd31,4'd15}, 1'b0);
        check(hit_err == 1'b1, "R8", "error set", 64'(hit_err), 1);
        step('0, 1'b1);
        check_bank("R8");
        check(int'(cell_of(1*PB + 1)) == 1, "R8", "good hit kept",
              64'(cell_of(1*PB + 1)), 1);
        repeat (4) @(negedge clk);
        check(hit_err == 1'b1, "R8", "error sticky", 64'(hit_err), 1);

        // R1 reset clears everything again
        do_reset();
        check(hit_err == 1'b0, "R1", "error cleared", 64'(hit_err), 0);
        check(hist_out == '0, "R1", "bank cleared", 64'(|hist_out), 0);
        step('0, 1'b1);
        check_bank("R1");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule